// File: doc/BRIEF.md
# IMA Cell-Rate Clock Divider

This block turns a bit-rate enable into a cell-rate enable for several independent link groups. There are 16 channels by default. Each channel scales its incoming rate with a fractional accumulator. On every source tick the accumulator gains N×P. When it reaches 424×(P+F), a cell slot is produced and that threshold is taken off again. Here M is the frame length in cells, N the number of links, P the frame payload and F the frame overhead bits. Because only integers are involved, the long-run ratio is exact.

Each slot is then sorted into one of three kinds:
- A slot at frame position 0 is a control-cell slot and produces no pulse.
- Every other position produces a one-cycle data-cell pulse.
- After 2048 slots have been emitted, the next slot is dropped as a stuff event. This gives the 2048/2049 rate factor.

A per-channel select picks the tick source. It is either that channel's own bit-rate enable or a shared system-clock divide-by-24 tick. The shared tick is the right choice when the system clock runs at 24 times the bit rate.

Configuration inputs are captured at the first edge after reset and again at each control-cell slot. The frame in progress therefore never sees a parameter change.

Top module: `cell_rate_divider`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after its release, `cell_pulse` is all zero. The tick present at the first edge after release is ignored.
- R2: On each effective tick a channel adds N×P to its accumulator. If the sum is at least 424×(P+F), a cell slot occurs and the threshold is subtracted; otherwise the sum is kept. The configuration must satisfy N×P < 424×(P+F).
- R3: `cfg_src_sel[c]`=0 takes ticks from `bit_en[c]`; `cfg_src_sel[c]`=1 takes the shared tick. The shared tick is consumed at the 24th, 48th, 72nd, … rising edge after reset release.
- R4: Frame position counts slots from 0 to M-1 and then wraps. A slot at position 0 is a control-cell slot and gives no pulse. A slot at any other position gives `cell_pulse[c]`=1 for exactly the cycle after the edge that consumed the tick.
- R5: Once 2048 control and data slots have been emitted since reset or since the last stuff event, the next slot is a stuff event. It gives no pulse, does not advance the frame position and restarts the count at zero.
- R6: When a stuff event falls on frame position 0, the stuff event takes that slot. The control-cell slot is taken by the following slot.
- R7: The fields `cfg_src_sel`, `cfg_m`, `cfg_n`, `cfg_p` and `cfg_f` are captured at the first edge after reset and at each control-cell slot. They govern ticks from the next edge onward. Changes at other times have no effect until then. M must be at least 2.
- R8: Channels are independent; the stimulus and configuration of one never change another's pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bit_en | input | NUM_CH | Per-channel bit-rate enable from an upstream generator |
| cfg_src_sel | input | NUM_CH | Per-channel source: 0 own enable, 1 shared divide-by-24 tick |
| cfg_m | input | NUM_CH×9 | Frame length M per channel, channel c at bits [c×9 +: 9] |
| cfg_n | input | NUM_CH×6 | Link count N per channel, channel c at bits [c×6 +: 6] |
| cfg_p | input | NUM_CH×12 | Frame payload P per channel, channel c at bits [c×12 +: 12] |
| cfg_f | input | NUM_CH×8 | Frame overhead bits F per channel, channel c at bits [c×8 +: 8] |
| cell_pulse | output | NUM_CH | One-cycle data-cell pulse per channel |

## Verification
A stuff event and a control-cell slot can contend for the same slot. The bench provokes this by holding M at 32 on a channel that ticks every cycle. With that setting the 2048th emitted slot always closes a frame, so every stuff event lands on frame position 0. The bench's own model gives the stuff event that slot and the control slot the next one. The scoreboard then judges the exact edge of each following data pulse, and a wrong priority shifts every pulse of the frame by one slot.

// File: rtl/cellrate_pkg.sv
package cellrate_pkg;

  localparam int M_W       = 9;
  localparam int N_W       = 6;
  localparam int P_W       = 12;
  localparam int F_W       = 8;
  localparam int CELL_BITS = 424;
  localparam int STUFF_GAP = 2048;
  localparam int SRC_DIV   = 24;

  localparam int THR_W     = P_W + 1 + $clog2(CELL_BITS);
  localparam int EMIT_W    = $clog2(STUFF_GAP + 1);

  typedef struct packed {
    logic           src_sel;
    logic [M_W-1:0] m;
    logic [N_W-1:0] n;
    logic [P_W-1:0] p;
    logic [F_W-1:0] f;
  } chan_cfg_t;

endpackage

// File: rtl/sysclk_tick_div.sv
module sysclk_tick_div #(
  parameter int DIV = 24
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = $clog2(DIV);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == CW'(DIV - 1));

  always_comb begin
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cell_slot_acc.sv
module cell_slot_acc
  import cellrate_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      cfg_load,
  input  chan_cfg_t cfg_in,
  output chan_cfg_t cfg_act,
  output logic      slot
);
  localparam int SUM_W = THR_W + 1;

  logic             loaded_q;
  logic [THR_W-1:0] acc_q, acc_d;
  chan_cfg_t        cfg_q, cfg_d;
  logic             tick_eff;
  logic [THR_W-1:0] step, thr;
  logic [SUM_W-1:0] sum;
  logic             cfg_en;

  assign cfg_act  = cfg_q;
  assign tick_eff = tick & loaded_q;
  assign cfg_en   = ~loaded_q | cfg_load;

  always_comb begin
    step = THR_W'(cfg_q.n) * THR_W'(cfg_q.p);
    thr  = (THR_W'(cfg_q.p) + THR_W'(cfg_q.f)) * THR_W'(CELL_BITS);
    sum  = {1'b0, acc_q} + {1'b0, step};
    slot = tick_eff & (sum >= {1'b0, thr});
    if (!tick_eff)  acc_d = acc_q;
    else if (slot)  acc_d = THR_W'(sum - {1'b0, thr});
    else            acc_d = sum[THR_W-1:0];
    cfg_d = cfg_en ? cfg_in : cfg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded_q <= 1'b0;
      acc_q    <= '0;
      cfg_q    <= '0;
    end else begin
      loaded_q <= 1'b1;
      acc_q    <= acc_d;
      cfg_q    <= cfg_d;
    end
  end
endmodule

// File: rtl/cell_frame_seq.sv
module cell_frame_seq
  import cellrate_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           slot,
  input  logic [M_W-1:0] m_act,
  output logic           cfg_load,
  output logic           stuff_evt,
  output logic           pulse
);
  logic [M_W-1:0]    pos_q, pos_d;
  logic [EMIT_W-1:0] emit_q, emit_d;
  logic              pulse_d;
  logic              stuff_due, emitted, data_slot;

  always_comb begin
    stuff_due = (emit_q == EMIT_W'(STUFF_GAP));
    stuff_evt = slot & stuff_due;
    emitted   = slot & ~stuff_due;
    cfg_load  = emitted & (pos_q == '0);
    data_slot = emitted & (pos_q != '0);

    emit_d = emit_q;
    if (stuff_evt)    emit_d = '0;
    else if (emitted) emit_d = emit_q + 1'b1;

    pos_d = pos_q;
    if (emitted) pos_d = (pos_q == m_act - 1'b1) ? '0 : pos_q + 1'b1;

    pulse_d = data_slot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      emit_q <= '0;
      pulse  <= 1'b0;
    end else begin
      pos_q  <= pos_d;
      emit_q <= emit_d;
      pulse  <= pulse_d;
    end
  end
endmodule

// File: rtl/cell_rate_divider.sv
module cell_rate_divider
  import cellrate_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_CH-1:0]     bit_en,
  input  logic [NUM_CH-1:0]     cfg_src_sel,
  input  logic [NUM_CH*M_W-1:0] cfg_m,
  input  logic [NUM_CH*N_W-1:0] cfg_n,
  input  logic [NUM_CH*P_W-1:0] cfg_p,
  input  logic [NUM_CH*F_W-1:0] cfg_f,
  output logic [NUM_CH-1:0]     cell_pulse
);
  logic              tick24;
  logic [NUM_CH-1:0] src_tick;
  logic [NUM_CH-1:0] slot_evt;
  logic [NUM_CH-1:0] stuff_evt;
  logic [NUM_CH-1:0] cfg_load;

  sysclk_tick_div #(.DIV(SRC_DIV)) u_div24 (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick24)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    chan_cfg_t cfg_in, cfg_act;

    assign cfg_in.src_sel = cfg_src_sel[c];
    assign cfg_in.m       = cfg_m[c*M_W +: M_W];
    assign cfg_in.n       = cfg_n[c*N_W +: N_W];
    assign cfg_in.p       = cfg_p[c*P_W +: P_W];
    assign cfg_in.f       = cfg_f[c*F_W +: F_W];

    assign src_tick[c] = cfg_act.src_sel ? tick24 : bit_en[c];

    cell_slot_acc u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (src_tick[c]),
      .cfg_load(cfg_load[c]),
      .cfg_in  (cfg_in),
      .cfg_act (cfg_act),
      .slot    (slot_evt[c])
    );

    cell_frame_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .slot     (slot_evt[c]),
      .m_act    (cfg_act.m),
      .cfg_load (cfg_load[c]),
      .stuff_evt(stuff_evt[c]),
      .pulse    (cell_pulse[c])
    );
  end
endmodule

// File: rtl/cellrate_chk.sv
module cellrate_chk
  import cellrate_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick24,
  input logic [NUM_CH-1:0] src_tick,
  input logic [NUM_CH-1:0] slot_evt,
  input logic [NUM_CH-1:0] stuff_evt,
  input logic [NUM_CH-1:0] cell_pulse
);
  localparam int GW = $clog2(SRC_DIV);

  logic [GW-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap_q <= '0;
    else        gap_q <= tick24 ? '0 : gap_q + 1'b1;
  end

  // R3: shared tick exactly every SRC_DIV edges
  always_ff @(posedge clk) begin
    if (rst_n && tick24)
      p_div24_period_r3: assert (gap_q == GW'(SRC_DIV - 1));
  end

  // R1: no pulse while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n)
      p_reset_quiet_r1: assert (cell_pulse == '0);
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [EMIT_W-1:0] emit_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      emit_q <= '0;
      else if (stuff_evt[c])           emit_q <= '0;
      else if (slot_evt[c])            emit_q <= emit_q + 1'b1;
    end

    // R5: stuff event after exactly STUFF_GAP emitted slots
    always_ff @(posedge clk) begin
      if (rst_n && stuff_evt[c])
        p_stuff_gap_r5: assert (emit_q == EMIT_W'(STUFF_GAP));
    end

    p_slot_needs_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      slot_evt[c] |-> src_tick[c]);

    p_pulse_from_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cell_pulse[c] |-> $past(slot_evt[c] && !stuff_evt[c]));

    p_stuff_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
      stuff_evt[c] |=> !cell_pulse[c]);
  end
endmodule

bind cell_rate_divider cellrate_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick24    (tick24),
  .src_tick  (src_tick),
  .slot_evt  (slot_evt),
  .stuff_evt (stuff_evt),
  .cell_pulse(cell_pulse)
);

// File: tb/cell_rate_divider_tb.sv
module cell_rate_divider_tb;
  import cellrate_pkg::*;

  localparam int NCH = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0]     bit_en = '0;
  logic [NCH-1:0]     cfg_src_sel = '0;
  logic [NCH*M_W-1:0] cfg_m = '0;
  logic [NCH*N_W-1:0] cfg_n = '0;
  logic [NCH*P_W-1:0] cfg_p = '0;
  logic [NCH*F_W-1:0] cfg_f = '0;
  logic [NCH-1:0]     cell_pulse;

  always #5 clk = ~clk;

  cell_rate_divider #(.NUM_CH(NCH)) u_dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .cfg_src_sel(cfg_src_sel),
    .cfg_m(cfg_m), .cfg_n(cfg_n), .cfg_p(cfg_p), .cfg_f(cfg_f),
    .cell_pulse(cell_pulse)
  );

  int compared = 0;
  int mismatched = 0;
  int edges = 0;
  bit done = 1'b0;

  // tag codes: 2=R2 3=R3 4=R4 6=R6 7=R7
  int exp_q0[$];
  int exp_q1[$];
  int seen[NCH];
  int pushed[NCH];

  // current input configuration, mirrored onto the ports
  int cur_m[NCH], cur_n[NCH], cur_p[NCH], cur_f[NCH];
  // model state
  bit m_ld[NCH];
  longint m_acc[NCH];
  int m_pos[NCH], m_emit[NCH], m_tag[NCH], m_stuffs[NCH];
  int a_m[NCH], a_n[NCH], a_p[NCH], a_f[NCH];

  function automatic string tag_name(int t);
    case (t)
      3: return "R3";
      4: return "R4";
      6: return "R6";
      7: return "R7";
      default: return "R2";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) edges <= 0;
    else        edges <= edges + 1;
  end

  task automatic apply_cfg();
    for (int c = 0; c < NCH; c++) begin
      cfg_m[c*M_W +: M_W] = M_W'(cur_m[c]);
      cfg_n[c*N_W +: N_W] = N_W'(cur_n[c]);
      cfg_p[c*P_W +: P_W] = P_W'(cur_p[c]);
      cfg_f[c*F_W +: F_W] = F_W'(cur_f[c]);
    end
  endtask

  task automatic push_exp(int c, int e);
    int item;
    item = e * 8 + m_tag[c];
    if (c == 0) exp_q0.push_back(item);
    else        exp_q1.push_back(item);
    pushed[c]++;
    m_tag[c] = (c == 0) ? 2 : 3;
  endtask

  task automatic load_act(int c);
    bit changed;
    changed = (a_n[c] != cur_n[c]) || (a_p[c] != cur_p[c]) ||
              (a_f[c] != cur_f[c]) || (a_m[c] != cur_m[c]);
    a_m[c] = cur_m[c]; a_n[c] = cur_n[c]; a_p[c] = cur_p[c]; a_f[c] = cur_f[c];
    if (changed && m_ld[c] && m_tag[c] < 6) m_tag[c] = 7;
  endtask

  // requirement model: the edge numbered e consumes tick tk
  task automatic model_edge(int c, bit tk, int e);
    longint sum, thr;
    if (!m_ld[c]) begin
      load_act(c);
      m_ld[c] = 1'b1;
      return;
    end
    if (!tk) return;
    sum = m_acc[c] + longint'(a_n[c]) * a_p[c];
    thr = longint'(CELL_BITS) * (a_p[c] + a_f[c]);
    if (sum < thr) begin
      m_acc[c] = sum;
      return;
    end
    m_acc[c] = sum - thr;
    if (m_emit[c] == STUFF_GAP) begin
      m_emit[c] = 0;
      m_stuffs[c]++;
      if (m_pos[c] == 0) m_tag[c] = 6;
    end else begin
      m_emit[c]++;
      if (m_pos[c] == 0) begin
        m_pos[c] = (a_m[c] == 1) ? 0 : 1;
        if (m_tag[c] < 4) m_tag[c] = 4;
        load_act(c);
      end else begin
        push_exp(c, e);
        m_pos[c] = (m_pos[c] == a_m[c] - 1) ? 0 : m_pos[c] + 1;
      end
    end
  endtask

  // monitor: pops expected pulses and compares edges
  task automatic mon_ch(int c);
    int item;
    bit have;
    have = (c == 0) ? (exp_q0.size() > 0) : (exp_q1.size() > 0);
    item = have ? ((c == 0) ? exp_q0[0] : exp_q1[0]) : 0;
    if (cell_pulse[c]) begin
      seen[c]++;
      compared++;
      if (!have) begin
        mismatched++;
        $display("FAIL R4 ch%0d unexpected pulse: actual edge %0d, expected none", c, edges);
      end else begin
        if (c == 0) void'(exp_q0.pop_front()); else void'(exp_q1.pop_front());
        if (item / 8 != edges) begin
          mismatched++;
          $display("FAIL %s ch%0d pulse edge: actual %0d, expected %0d",
                   tag_name(item % 8), c, edges, item / 8);
        end
      end
    end else if (have && item / 8 <= edges) begin
      compared++;
      mismatched++;
      if (c == 0) void'(exp_q0.pop_front()); else void'(exp_q1.pop_front());
      $display("FAIL %s ch%0d missing pulse: actual none, expected edge %0d",
               tag_name(item % 8), c, item / 8);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int c = 0; c < NCH; c++) mon_ch(c);
    end
  end

  task automatic check(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d, expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout, expected end of run");
    finish_run();
  end

  initial begin : driver
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    for (int c = 0; c < NCH; c++) begin
      m_ld[c] = 0; m_acc[c] = 0; m_pos[c] = 0; m_emit[c] = 0;
      m_tag[c] = (c == 0) ? 2 : 3; m_stuffs[c] = 0; seen[c] = 0; pushed[c] = 0;
      a_m[c] = 0; a_n[c] = 0; a_p[c] = 0; a_f[c] = 0;
    end
    // ch0: own enable, M=32 so every stuff event meets frame position 0 (R6)
    cur_m[0] = 32; cur_n[0] = 63; cur_p[0] = 424; cur_f[0] = 0;
    // ch1: shared divide-by-24 tick (R3)
    cur_m[1] = 6;  cur_n[1] = 63; cur_p[1] = 424; cur_f[1] = 0;
    cfg_src_sel = 2'b10;
    apply_cfg();

    // R1: quiet during reset
    repeat (4) @(negedge clk);
    check("R1 pulse during reset", int'(cell_pulse), 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int cyc = 0; cyc < 36000; cyc++) begin
      int e;
      e = edges + 1;
      if (cyc == 1) check("R1 pulse first cycle after reset", int'(cell_pulse), 0);
      if (cyc == 16000) begin
        // R7: new rates presented mid-frame, held until next control slot
        cur_n[0] = 40; cur_p[0] = 1000; cur_f[0] = 60;
        apply_cfg();
      end
      if (cyc == 10000) begin
        cur_m[1] = 4; cur_n[1] = 50; cur_p[1] = 800; cur_f[1] = 20;
        apply_cfg();
      end
      if (cyc < 16000) bit_en[0] = 1'b1;
      else begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        bit_en[0] = lfsr[0];
      end
      // ch1 ignores its own enable (R3/R8): toggle it anyway
      bit_en[1] = lfsr[3];
      model_edge(0, bit_en[0], e);
      model_edge(1, (e % SRC_DIV) == 0, e);
      @(negedge clk);
    end
    bit_en = '0;
    repeat (4) @(negedge clk);

    check("R4 ch0 data pulses seen", seen[0], pushed[0]);
    check("R3 ch1 data pulses seen", seen[1], pushed[1]);
    check("R5 ch0 model reached a stuff event", int'(m_stuffs[0] > 0), 1);
    check("R8 ch0 queue drained", exp_q0.size(), 0);
    check("R8 ch1 queue drained", exp_q1.size(), 0);
    finish_run();
  end
endmodule